// File: doc/BRIEF.md
# Linked-List Command Packet Walker

The walker traverses a chain of command packets held in a 2 MB system memory and streams the payload words of every packet, in order, to a downstream command consumer. Each packet starts with a header word carrying a payload word count and the byte address of the following header. A walk is launched with a start address. It runs until it reaches the end-of-list value or a header it has already seen.

Cyclic lists are caught by tagging each visited header in memory. After the forward pass, a second pass starting from the same address revisits the same number of headers and removes the tags. When that pass ends, the block raises a one-cycle completion pulse. With it come an estimated processing cost and the number of headers visited.

The memory port is a simple synchronous single-port interface with a one-cycle read latency. The payload leaves on a valid/ready stream.

Top module: `ll_dma_walker`

## Requirements
- R1: A header word holds the payload count in bits 31:24 and the next header byte address in bits 23:0. The count words directly after the header are its payload.
- R2: Payload words go out on the stream in memory order, one per accepted transfer. A header with count zero sends no payload.
- R3: The walk stops after a header whose next-address field equals 0xFFFFFF. A start address of 0xFFFFFF visits no header, causes no memory access, and completes with cost 0 and node count 0.
- R4: Every address is reduced to its low 21 bits and word aligned, so the memory word index is bits 20:2. Payload reads that run past the top of the 2 MB range wrap to word 0.
- R5: Each header is read, then written back to the same word exactly two cycles later with bit 23 set and all other bits unchanged. Read and write strobes are never active together.
- R6: The next-address field is taken from the header as read, before the tag is written. If its bit 23 is already set, that header's payload is still sent and the walk then stops. A list that loops back therefore replays the revisited header once.
- R7: The clearing pass starts again at the start address and follows the next-address fields for as many headers as the forward pass counted. It writes each header back with bit 23 cleared, the last header included.
- R8: The cost is 10 per visited header, plus 5 + count for each header whose count is non-zero. The node count is the number of headers visited, revisits included.
- R9: `done` is high for exactly one cycle, one cycle after the last clearing write. `cost` and `node_count` carry the final values then and hold them until the next start.
- R10: While `pay_valid` is high and `pay_ready` is low, `pay_valid` stays high and `pay_data` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk (sampled only when idle) |
| start_addr | input | 24 | Byte address of the first header |
| busy | output | 1 | A walk or clearing pass is in progress |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | 19 | Memory word index |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid the cycle after `mem_rd` |
| pay_valid | output | 1 | Payload word available |
| pay_ready | input | 1 | Consumer accepts the payload word |
| pay_data | output | 32 | Payload word |
| done | output | 1 | One-cycle completion pulse |
| cost | output | 32 | Estimated processing cost of the last walk |
| node_count | output | 16 | Headers visited in the last walk |

## Verification
The assertions assume that memory returns read data exactly one cycle after `mem_rd` and that nothing else writes memory during a walk. They also assume that `start` is only taken while the block is idle. The bench's memory model answers every read on the following edge and is touched only by the block. Walks are launched only after the previous `done`. The consumer's ready is toggled freely, since the stream properties must hold under any stall pattern.

// File: rtl/ll_dma_walker.sv
module ll_dma_walker #(
  parameter int AW     = 21,
  parameter int CNT_W  = 16,
  parameter int COST_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [23:0]       start_addr,
  output logic              busy,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [AW-3:0]     mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  output logic              pay_valid,
  input  logic              pay_ready,
  output logic [31:0]       pay_data,
  output logic              done,
  output logic [COST_W-1:0] cost,
  output logic [CNT_W-1:0]  node_count
);
  localparam int          WAW      = AW - 2;
  localparam logic [23:0] END_ADDR = 24'hFFFFFF;
  localparam int          TAG      = 23;

  typedef enum logic [3:0] {
    S_IDLE, S_HRD, S_HWAIT, S_HWR, S_PRD, S_PWAIT, S_PSEND,
    S_NEXT, S_CRD, S_CWAIT, S_CWR, S_DONE
  } state_t;

  state_t           state;
  logic [WAW-1:0]   cur, first, ptr;
  logic [31:0]      hdr, pay_q;
  logic [7:0]       rem;
  logic [CNT_W-1:0] clr_left;

  wire [7:0] rd_cnt = mem_rdata[31:24];
  wire       last   = (hdr[23:0] == END_ADDR) || hdr[TAG];

  assign busy      = (state != S_IDLE);
  assign mem_rd    = (state == S_HRD) || (state == S_PRD) || (state == S_CRD);
  assign mem_wr    = (state == S_HWR) || (state == S_CWR);
  assign mem_addr  = (state == S_PRD) ? ptr : cur;
  assign mem_wdata = (state == S_HWR) ? (hdr | (32'd1 << TAG)) : (hdr & ~(32'd1 << TAG));
  assign pay_valid = (state == S_PSEND);
  assign pay_data  = pay_q;
  assign done      = (state == S_DONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      cur        <= '0;
      first      <= '0;
      ptr        <= '0;
      hdr        <= '0;
      pay_q      <= '0;
      rem        <= '0;
      clr_left   <= '0;
      cost       <= '0;
      node_count <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          cur        <= start_addr[AW-1:2];
          first      <= start_addr[AW-1:2];
          cost       <= '0;
          node_count <= '0;
          state      <= (start_addr == END_ADDR) ? S_DONE : S_HRD;
        end
        S_HRD:   state <= S_HWAIT;
        S_HWAIT: begin
          hdr        <= mem_rdata;
          node_count <= node_count + CNT_W'(1);
          cost       <= cost + COST_W'(10) +
                        ((rd_cnt != 8'd0) ? (COST_W'(5) + COST_W'(rd_cnt)) : COST_W'(0));
          state      <= S_HWR;
        end
        S_HWR: begin
          if (hdr[31:24] != 8'd0) begin
            rem   <= hdr[31:24];
            ptr   <= cur + WAW'(1);
            state <= S_PRD;
          end else begin
            state <= S_NEXT;
          end
        end
        S_PRD:   state <= S_PWAIT;
        S_PWAIT: begin
          pay_q <= mem_rdata;
          state <= S_PSEND;
        end
        S_PSEND: if (pay_ready) begin
          rem   <= rem - 8'd1;
          ptr   <= ptr + WAW'(1);
          state <= (rem == 8'd1) ? S_NEXT : S_PRD;
        end
        S_NEXT: begin
          if (last) begin
            cur      <= first;
            clr_left <= node_count;
            state    <= S_CRD;
          end else begin
            cur   <= hdr[AW-1:2];
            state <= S_HRD;
          end
        end
        S_CRD:   state <= S_CWAIT;
        S_CWAIT: begin
          hdr   <= mem_rdata;
          state <= S_CWR;
        end
        S_CWR: begin
          clr_left <= clr_left - CNT_W'(1);
          if (clr_left == CNT_W'(1)) begin
            state <= S_DONE;
          end else begin
            cur   <= hdr[AW-1:2];
            state <= S_CRD;
          end
        end
        S_DONE:  state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_rd_wr_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  assert_rmw_same_word_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> ($past(mem_rd, 2) && (mem_addr == $past(mem_addr, 2))));

  assert_pay_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pay_valid && !pay_ready) |=> (pay_valid && $stable(pay_data)));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && $stable(cost) && $stable(node_count)));

  assert_quiet_when_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_rd && !mem_wr && !pay_valid));
endmodule

// File: tb/sim_ll_dma_walker.sv
module sim_ll_dma_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [23:0] start_addr = '0;
  logic        busy, mem_rd, mem_wr, pay_valid, done;
  logic [18:0] mem_addr;
  logic [31:0] mem_wdata, pay_data;
  logic [31:0] mem_rdata = '0;
  logic        pay_ready = 1'b1;
  logic [31:0] cost;
  logic [15:0] node_count;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit stall_mode = 1'b0;
  int stall_ctr = 0;

  logic [31:0] mem [int unsigned];
  logic [31:0] got [$];
  logic [50:0] wlog [$];

  always #10 clk = ~clk;

  ll_dma_walker u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr), .busy(busy),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .pay_valid(pay_valid), .pay_ready(pay_ready),
    .pay_data(pay_data), .done(done), .cost(cost), .node_count(node_count)
  );

  function automatic logic [31:0] peek(int unsigned a);
    return mem.exists(a) ? mem[a] : 32'd0;
  endfunction

  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= peek(int'(mem_addr));
    if (mem_wr) begin
      mem[int'(mem_addr)] = mem_wdata;
      wlog.push_back({mem_addr, mem_wdata});
    end
    if (pay_valid && pay_ready) got.push_back(pay_data);
  end

  always @(negedge clk) begin
    stall_ctr <= stall_ctr + 1;
    pay_ready <= stall_mode ? (stall_ctr % 3 == 2) : 1'b1;
  end

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      checks++;
      $display("FAIL R9 watchdog expired actual busy expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic run_walk(logic [23:0] sa);
    got.delete();
    wlog.delete();
    @(negedge clk);
    start = 1'b1;
    start_addr = sa;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 20000; i++) begin
      if (done) break;
      @(negedge clk);
    end
    chk(done == 1'b1, "R9 done seen", 64'(done), 64'd1);
  endtask

  task automatic check_done_hold(logic [31:0] exp_cost, logic [15:0] exp_nodes);
    chk(cost == exp_cost, "R8 cost", 64'(cost), 64'(exp_cost));
    chk(node_count == exp_nodes, "R8 node count", 64'(node_count), 64'(exp_nodes));
    @(negedge clk);
    chk(done == 1'b0, "R9 done single cycle", 64'(done), 64'd0);
    chk(cost == exp_cost, "R9 cost held", 64'(cost), 64'(exp_cost));
  endtask

  task automatic t_reset;
    chk(!done && !busy && !pay_valid && !mem_rd && !mem_wr, "R9 reset idle outputs",
        64'({done, busy, pay_valid, mem_rd, mem_wr}), 64'd0);
    chk(cost == 0 && node_count == 0, "R8 reset counters", 64'({cost, node_count}), 64'd0);
  endtask

  task automatic t_chain;
    logic [31:0] ha = {8'd2, 24'h200200};
    logic [31:0] hb = {8'd0, 24'h600300};
    logic [31:0] hc = {8'd1, 24'hFFFFFF};
    logic [31:0] exp_pay [3] = '{32'hA0000001, 32'hA0000002, 32'hC0000001};
    logic [50:0] exp_w [6];
    mem.delete();
    mem[32'h40] = ha; mem[32'h41] = exp_pay[0]; mem[32'h42] = exp_pay[1];
    mem[32'h80] = hb; mem[32'h81] = 32'hDEAD0000;
    mem[32'hC0] = hc; mem[32'hC1] = exp_pay[2];
    exp_w[0] = {19'h40, ha | 32'h0080_0000};
    exp_w[1] = {19'h80, hb | 32'h0080_0000};
    exp_w[2] = {19'hC0, hc | 32'h0080_0000};
    exp_w[3] = {19'h40, ha & ~32'h0080_0000};
    exp_w[4] = {19'h80, hb & ~32'h0080_0000};
    exp_w[5] = {19'hC0, hc & ~32'h0080_0000};
    run_walk(24'h000100);
    chk(got.size() == 3, "R2 payload count, zero-count node sends none",
        64'(got.size()), 64'd3);
    for (int i = 0; i < 3; i++)
      if (i < got.size()) chk(got[i] == exp_pay[i], "R1 payload word order",
                              64'(got[i]), 64'(exp_pay[i]));
    chk(wlog.size() == 6, "R5 header write count", 64'(wlog.size()), 64'd6);
    for (int i = 0; i < 3; i++)
      if (i < wlog.size()) chk(wlog[i] == exp_w[i], "R5 tag write, next masked R4",
                               64'(wlog[i]), 64'(exp_w[i]));
    for (int i = 3; i < 6; i++)
      if (i < wlog.size()) chk(wlog[i] == exp_w[i], "R7 clear write",
                               64'(wlog[i]), 64'(exp_w[i]));
    check_done_hold(32'd43, 16'd3);
  endtask

  task automatic t_sentinel;
    run_walk(24'hFFFFFF);
    chk(wlog.size() == 0 && got.size() == 0, "R3 sentinel start no traffic",
        64'(wlog.size() + got.size()), 64'd0);
    check_done_hold(32'd0, 16'd0);
  endtask

  task automatic t_loop;
    logic [31:0] ha = {8'd1, 24'h000500};
    logic [31:0] hb = {8'd1, 24'h000400};
    logic [31:0] exp_pay [3] = '{32'h11110000, 32'h22220000, 32'h11110000};
    mem.delete();
    mem[32'h100] = ha; mem[32'h101] = 32'h11110000;
    mem[32'h140] = hb; mem[32'h141] = 32'h22220000;
    run_walk(24'h000400);
    chk(got.size() == 3, "R6 loop replays revisited node once", 64'(got.size()), 64'd3);
    for (int i = 0; i < 3; i++)
      if (i < got.size()) chk(got[i] == exp_pay[i], "R6 loop payload",
                              64'(got[i]), 64'(exp_pay[i]));
    chk(wlog.size() == 6, "R7 clear pass length", 64'(wlog.size()), 64'd6);
    chk(peek(32'h100) == ha && peek(32'h140) == hb, "R7 headers restored",
        64'({peek(32'h100), peek(32'h140)}), 64'({ha, hb}));
    check_done_hold(32'd48, 16'd3);
  endtask

  task automatic t_wrap_stall;
    logic [31:0] h = {8'd2, 24'hFFFFFF};
    mem.delete();
    mem[32'h7FFFF] = h; mem[32'h0] = 32'h55550001; mem[32'h1] = 32'h55550002;
    stall_mode = 1'b1;
    run_walk(24'hFFFFFC);
    stall_mode = 1'b0;
    chk(got.size() == 2, "R4 wrapped payload count", 64'(got.size()), 64'd2);
    if (got.size() == 2) begin
      chk(got[0] == 32'h55550001, "R4 wrap word 0 under stall R10", 64'(got[0]), 64'h55550001);
      chk(got[1] == 32'h55550002, "R4 wrap word 1 under stall R10", 64'(got[1]), 64'h55550002);
    end
    chk(peek(32'h7FFFF) == (h & ~32'h0080_0000), "R7 top header cleared",
        64'(peek(32'h7FFFF)), 64'(h & ~32'h0080_0000));
    check_done_hold(32'd17, 16'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_chain();
    t_sentinel();
    t_loop();
    t_wrap_stall();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule